// File: doc/BRIEF.md
# PLL Power-Up and Retune Sequencer

This block steps an analog PLL macro through its power-up, power-down and retune sequences. Each sequence runs in a fixed order, and the timed waits between its steps are counted in microseconds of a reference clock. The block drives the macro's supply switch, isolation clamp, loop enable, tuner enable, reset release and divider-change strobe. It also drives the divider fields that the macro samples. The power-down sequence undoes the power-up steps in reverse order, so that the loop is never enabled while the macro is isolated or unpowered.

A controller makes one of three requests: start-up, shut-down or retune. A retune carries a feedback word and a post-divider value. Only an idle block accepts a request, and it acknowledges it in the same cycle. While a sequence is running, `busy` stays high and requests are neither acknowledged nor acted on. `ready` shows whether the loop enable is set.

Top module: `pll_seq`

## Requirements
- R1: After reset, `pwr_on`, `pll_en`, `tuner_en`, `rst_rel`, `pcw_chg`, `busy`, `ready`, `pcw_out`, `pdiv_out` and `tuner_word` are all 0, and `iso_en` is 1.
- R2: An accepted start-up request sets `pwr_on` at the accepting clock edge, while `iso_en` stays 1.
- R3: `iso_en` clears exactly T_STEP_US·REF_PER_US cycles after `pwr_on` rises. `pll_en` and `tuner_en` rise together another T_STEP_US·REF_PER_US cycles later.
- R4: T_SETTLE_US·REF_PER_US cycles after the enable rises, `rst_rel` rises and `busy` falls in the same cycle. `ready` equals `pll_en`.
- R5: An accepted shut-down request makes one change per clock edge, in this order: `rst_rel` low, `tuner_en` low, `pll_en` low, `iso_en` high, `pwr_on` low. `busy` falls with the last of these changes.
- R6: A retune first loads `pdiv_out` with the bit index of the lowest set bit of `tune_div` (0 when `tune_div` is 0). One cycle later it loads `pcw_out` with `tune_pcw`.
- R7: If `pll_en` is 1 when the feedback word is loaded, `pcw_chg` rises in that cycle. It stays high for T_SETTLE_US·REF_PER_US cycles, and `busy` falls when it falls.
- R8: If `pll_en` is 0 at that point, `pcw_chg` stays 0 and `busy` falls in the same cycle that `pcw_out` is loaded.
- R9: When a tuner is configured, `tuner_word` is loaded with `tune_pcw`+1 (modulo 2^PCW_W) in the same cycle as `pcw_out`.
- R10: While `busy` is 1, `req_ack` is 0, and a request has no effect on any output.
- R11: When the block is idle and several requests arrive together, shut-down takes priority over start-up, and start-up takes priority over retune.
- R12: `pll_en` is only ever 1 while `pwr_on` is 1 and `iso_en` is 0. `rst_rel`, `tuner_en` and `pcw_chg` are only ever 1 while `pll_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Start-up request |
| down_req | input | 1 | Shut-down request |
| tune_req | input | 1 | Retune request |
| tune_pcw | input | PCW_W | Feedback word for a retune |
| tune_div | input | DIV_W | Post-divider value (power of two) for a retune |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | A sequence is running |
| ready | output | 1 | Loop enable is set |
| pwr_on | output | 1 | Macro supply on |
| iso_en | output | 1 | Macro isolation clamp active |
| pll_en | output | 1 | Loop enable |
| tuner_en | output | 1 | Tuner enable |
| rst_rel | output | 1 | Macro reset release |
| pcw_chg | output | 1 | Divider change strobe |
| pcw_out | output | PCW_W | Feedback word field |
| pdiv_out | output | log2(DIV_W) | Post-divider exponent field |
| tuner_word | output | PCW_W | Tuner load word |

## Verification
The assertions check the safety relations between the macro controls on every cycle. They cover enable only while the macro is powered and not isolated, isolation removed only after power is on, and reset release, tuner enable and strobe only while the loop is enabled. They also check that `req_ack` is never high while `busy` is, and that the feedback word holds steady during a strobe. Only the bench scenarios can show the exact wait lengths, the one-step-per-edge power-down order, the log2 encoding of the divider, the choice between strobed and unstrobed retunes, and request priority. They also show that a request refused while busy leaves the divider fields untouched.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PU_PWR,
      ST_PU_ISO,
      ST_PU_EN,
      ST_PD_TUN,
      ST_PD_EN,
      ST_PD_ISO,
      ST_PD_PWR,
      ST_RT_PCW,
      ST_RT_CHG
   } seq_state_e;

endpackage

// File: rtl/pll_seq_wait.sv
// Microsecond wait timer: after a load of N, done is high in the
// N*REF_PER_US-th cycle following the loading edge.
module pll_seq_wait #(
   parameter int REF_PER_US = 26,
   parameter int MAX_US     = 20,
   localparam int PRE_W = (REF_PER_US > 1) ? $clog2(REF_PER_US) : 1,
   localparam int US_W  = $clog2(MAX_US + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] us_cnt,
   output logic            done
);

   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(REF_PER_US - 1);

   logic [PRE_W-1:0] pre_q;
   logic [US_W-1:0]  us_q;
   logic             run_q;

   assign done = run_q && (pre_q == '0) && (us_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pre_q <= '0;
         us_q  <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         pre_q <= PRE_TOP;
         us_q  <= us_cnt - 1'b1;
      end else if (done) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         if (pre_q == '0) begin
            pre_q <= PRE_TOP;
            us_q  <= us_q - 1'b1;
         end else begin
            pre_q <= pre_q - 1'b1;
         end
      end
   end

   // R3: a wait of zero microseconds is never requested
   a_r3_nonzero_wait: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (us_cnt != '0));
   // R7: a new wait is only started once the previous one has ended
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!run_q || done));

endmodule

// File: rtl/pll_seq_log2enc.sv
// Post-divider exponent: bit index of the lowest set bit, 0 for an all-zero input.
module pll_seq_log2enc #(
   parameter int DIV_W = 8,
   localparam int PD_W = $clog2(DIV_W)
) (
   input  logic [DIV_W-1:0] div_in,
   output logic [PD_W-1:0]  exp_out
);

   always_comb begin
      exp_out = '0;
      for (int i = DIV_W - 1; i >= 0; i--) begin
         if (div_in[i]) exp_out = PD_W'(i);
      end
   end

endmodule

// File: rtl/pll_seq.sv
module pll_seq #(
   parameter int REF_PER_US  = 26,
   parameter int T_STEP_US   = 1,
   parameter int T_SETTLE_US = 20,
   parameter int PCW_W       = 22,
   parameter int DIV_W       = 8,
   parameter bit HAS_TUNER   = 1'b1,
   parameter bit HAS_RSTB    = 1'b1,
   localparam int PD_W = $clog2(DIV_W),
   localparam int US_W = $clog2(T_SETTLE_US + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_req,
   input  logic             down_req,
   input  logic             tune_req,
   input  logic [PCW_W-1:0] tune_pcw,
   input  logic [DIV_W-1:0] tune_div,
   output logic             req_ack,
   output logic             busy,
   output logic             ready,
   output logic             pwr_on,
   output logic             iso_en,
   output logic             pll_en,
   output logic             tuner_en,
   output logic             rst_rel,
   output logic             pcw_chg,
   output logic [PCW_W-1:0] pcw_out,
   output logic [PD_W-1:0]  pdiv_out,
   output logic [PCW_W-1:0] tuner_word
);
   import pll_seq_pkg::*;

   initial begin
      assert (REF_PER_US >= 1) else $error("REF_PER_US must be at least 1");
      assert (T_STEP_US >= 1) else $error("T_STEP_US must be at least 1");
      assert (T_SETTLE_US >= T_STEP_US) else $error("T_SETTLE_US below T_STEP_US");
      assert (PCW_W >= 8 && PCW_W <= 32) else $error("PCW_W out of range");
      assert (DIV_W >= 2 && DIV_W <= 64) else $error("DIV_W out of range");
   end

   seq_state_e       st_q;
   logic             pwr_q, iso_q, en_q, tun_q, rstr_q, chg_q;
   logic [PCW_W-1:0] pcw_hold_q, pcw_q, tw_q;
   logic [PD_W-1:0]  pdiv_q, div_exp;
   logic             acc_up, acc_dn, acc_rt, idle;
   logic             w_load, w_done;
   logic [US_W-1:0]  w_us;

   pll_seq_log2enc #(.DIV_W(DIV_W)) u_enc (
      .div_in  (tune_div),
      .exp_out (div_exp)
   );

   pll_seq_wait #(.REF_PER_US(REF_PER_US), .MAX_US(T_SETTLE_US)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (w_load),
      .us_cnt (w_us),
      .done   (w_done)
   );

   // request arbitration: shut-down, then start-up, then retune
   always_comb begin
      idle    = (st_q == ST_IDLE);
      acc_dn  = idle && down_req;
      acc_up  = idle && up_req && !down_req;
      acc_rt  = idle && tune_req && !down_req && !up_req;
      req_ack = acc_dn || acc_up || acc_rt;
   end

   // wait timer loads
   always_comb begin
      w_load = 1'b0;
      w_us   = US_W'(T_STEP_US);
      unique case (st_q)
         ST_IDLE:   w_load = acc_up;
         ST_PU_PWR: w_load = w_done;
         ST_PU_ISO: begin
            w_load = w_done;
            w_us   = US_W'(T_SETTLE_US);
         end
         ST_RT_PCW: begin
            w_load = en_q;
            w_us   = US_W'(T_SETTLE_US);
         end
         default:   w_load = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pwr_q      <= 1'b0;
         iso_q      <= 1'b1;
         en_q       <= 1'b0;
         tun_q      <= 1'b0;
         rstr_q     <= 1'b0;
         chg_q      <= 1'b0;
         pcw_hold_q <= '0;
         pcw_q      <= '0;
         tw_q       <= '0;
         pdiv_q     <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (acc_dn) begin
                  rstr_q <= 1'b0;
                  st_q   <= ST_PD_TUN;
               end else if (acc_up) begin
                  pwr_q <= 1'b1;
                  st_q  <= ST_PU_PWR;
               end else if (acc_rt) begin
                  pdiv_q     <= div_exp;
                  pcw_hold_q <= tune_pcw;
                  st_q       <= ST_RT_PCW;
               end
            end
            ST_PU_PWR: if (w_done) begin
               iso_q <= 1'b0;
               st_q  <= ST_PU_ISO;
            end
            ST_PU_ISO: if (w_done) begin
               en_q  <= 1'b1;
               tun_q <= 1'b1;
               st_q  <= ST_PU_EN;
            end
            ST_PU_EN: if (w_done) begin
               rstr_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_PD_TUN: begin
               tun_q <= 1'b0;
               st_q  <= ST_PD_EN;
            end
            ST_PD_EN: begin
               en_q <= 1'b0;
               st_q <= ST_PD_ISO;
            end
            ST_PD_ISO: begin
               iso_q <= 1'b1;
               st_q  <= ST_PD_PWR;
            end
            ST_PD_PWR: begin
               pwr_q <= 1'b0;
               st_q  <= ST_IDLE;
            end
            ST_RT_PCW: begin
               pcw_q <= pcw_hold_q;
               tw_q  <= pcw_hold_q + 1'b1;
               if (en_q) begin
                  chg_q <= 1'b1;
                  st_q  <= ST_RT_CHG;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
            ST_RT_CHG: if (w_done) begin
               chg_q <= 1'b0;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (HAS_TUNER) begin : g_tuner
         assign tuner_en   = tun_q;
         assign tuner_word = tw_q;
      end else begin : g_no_tuner
         assign tuner_en   = 1'b0;
         assign tuner_word = '0;
      end
      if (HAS_RSTB) begin : g_rstb
         assign rst_rel = rstr_q;
      end else begin : g_no_rstb
         assign rst_rel = 1'b0;
      end
   endgenerate

   assign busy     = !idle;
   assign ready    = en_q;
   assign pwr_on   = pwr_q;
   assign iso_en   = iso_q;
   assign pll_en   = en_q;
   assign pcw_chg  = chg_q;
   assign pcw_out  = pcw_q;
   assign pdiv_out = pdiv_q;

   // R10: no acknowledge while a sequence runs
   a_r10_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ack);
   // R12: enable only on a powered, unisolated macro
   a_r12_en_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> (pwr_on && !iso_en));
   // R12: dependent controls only while the loop is enabled
   a_r12_deps_need_en: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_rel || tuner_en || pcw_chg) |-> pll_en);
   // R3: isolation is removed only after power was already on
   a_r3_iso_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> $past(pwr_on));
   // R7: feedback word held steady while the strobe is up
   a_r7_pcw_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (pcw_chg && $past(pcw_chg)) |-> $stable(pcw_out));

endmodule

// File: tb/sim_pll_seq.sv
module sim_pll_seq;

   localparam int CLK_PERIOD = 10;
   localparam int R      = 26;
   localparam int PCW_W  = 22;
   localparam int DIV_W  = 8;
   localparam int PD_W   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_req = 1'b0, down_req = 1'b0, tune_req = 1'b0;
   logic [PCW_W-1:0] tune_pcw = '0;
   logic [DIV_W-1:0] tune_div = '0;
   logic req_ack, busy, ready, pwr_on, iso_en, pll_en, tuner_en, rst_rel, pcw_chg;
   logic [PCW_W-1:0] pcw_out, tuner_word;
   logic [PD_W-1:0]  pdiv_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit exp_en = 1'b0;
   logic [PCW_W-1:0] exp_pcw = '0;
   logic [PD_W-1:0]  exp_pdiv = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_seq #(.REF_PER_US(R), .PCW_W(PCW_W), .DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
      .tune_req(tune_req), .tune_pcw(tune_pcw), .tune_div(tune_div),
      .req_ack(req_ack), .busy(busy), .ready(ready), .pwr_on(pwr_on),
      .iso_en(iso_en), .pll_en(pll_en), .tuner_en(tuner_en), .rst_rel(rst_rel),
      .pcw_chg(pcw_chg), .pcw_out(pcw_out), .pdiv_out(pdiv_out),
      .tuner_word(tuner_word)
   );

   task automatic check(input string rq, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic logic [PD_W-1:0] lsb_idx(input logic [DIV_W-1:0] v);
      logic [PD_W-1:0] r = '0;
      for (int i = 0; i < DIV_W; i++) begin
         if (v[i]) begin
            r = PD_W'(i);
            break;
         end
      end
      return r;
   endfunction

   // drive a request at a falling edge; returns one edge after acceptance
   task automatic issue(input bit u, input bit d, input bit t,
                        input logic [PCW_W-1:0] p, input logic [DIV_W-1:0] v,
                        input string rq);
      @(negedge clk);
      up_req = u; down_req = d; tune_req = t; tune_pcw = p; tune_div = v;
      #1;
      check(rq, req_ack, 1);
      @(negedge clk);
      up_req = 0; down_req = 0; tune_req = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 40 * R; k++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   task automatic do_up();
      int c_iso = 0, c_en = 0, c_tun = 0, c_rst = 0, c_idle = 0, bad = 0;
      issue(1, 0, 0, '0, '0, "R2");
      check("R2 pwr_on", pwr_on, 1);
      check("R2 iso_en", iso_en, 1);
      for (int k = 1; k <= 30 * R; k++) begin
         if (k > 1) @(negedge clk);
         if (!iso_en && c_iso == 0) c_iso = k;
         if (pll_en && c_en == 0) c_en = k;
         if (tuner_en && c_tun == 0) c_tun = k;
         if (rst_rel && c_rst == 0) c_rst = k;
         if (pll_en && (!pwr_on || iso_en)) bad++;
         if (k == 4) tune_req = 0;
         if (!busy) begin
            c_idle = k;
            break;
         end
         if (k == 3) begin
            tune_req = 1; tune_pcw = ~exp_pcw; tune_div = 8'h40;
            #1;
            check("R10 ack while busy", req_ack, 0);
         end
      end
      tune_req = 0;
      check("R3 iso release", c_iso, R + 1);
      check("R3 enable", c_en, 2 * R + 1);
      check("R3 tuner", c_tun, 2 * R + 1);
      check("R4 rst_rel", c_rst, 22 * R + 1);
      check("R4 busy end", c_idle, 22 * R + 1);
      check("R4 ready", ready, 1);
      check("R10 pcw kept", pcw_out, exp_pcw);
      check("R10 pdiv kept", pdiv_out, exp_pdiv);
      check("R12 order", bad, 0);
      exp_en = 1;
   endtask

   task automatic do_down();
      issue(0, 1, 0, '0, '0, "R5");
      check("R5 s1 rst", rst_rel, 0);  check("R5 s1 tun", tuner_en, 1);
      @(negedge clk);
      check("R5 s2 tun", tuner_en, 0); check("R5 s2 en", pll_en, 1);
      @(negedge clk);
      check("R5 s3 en", pll_en, 0);    check("R5 s3 iso", iso_en, 0);
      @(negedge clk);
      check("R5 s4 iso", iso_en, 1);   check("R5 s4 pwr", pwr_on, 1);
      @(negedge clk);
      check("R5 s5 pwr", pwr_on, 0);   check("R5 s5 busy", busy, 0);
      check("R4 ready off", ready, 0);
      exp_en = 0;
   endtask

   task automatic do_tune(input logic [PCW_W-1:0] p, input logic [DIV_W-1:0] v);
      int c = 0;
      issue(0, 0, 1, p, v, "R6");
      check("R6 pdiv first", pdiv_out, lsb_idx(v));
      check("R6 pcw not yet", pcw_out, exp_pcw);
      check("R7 no early strobe", pcw_chg, 0);
      @(negedge clk);
      check("R6 pcw", pcw_out, p);
      check("R9 tuner word", tuner_word, PCW_W'(p + 1));
      if (exp_en) begin
         check("R7 strobe", pcw_chg, 1);
         for (int k = 3; k <= 30 * R; k++) begin
            @(negedge clk);
            if (!pcw_chg) begin
               c = k;
               break;
            end
         end
         check("R7 strobe length", c, 20 * R + 2);
         check("R7 busy end", busy, 0);
      end else begin
         check("R8 no strobe", pcw_chg, 0);
         check("R8 busy end", busy, 0);
      end
      exp_pcw = p;
      exp_pdiv = lsb_idx(v);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 pwr_on", pwr_on, 0);
      check("R1 iso_en", iso_en, 1);
      check("R1 pll_en", pll_en, 0);
      check("R1 misc", {tuner_en, rst_rel, pcw_chg, busy, ready}, 0);
      check("R1 fields", {pcw_out, pdiv_out, tuner_word}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: retune while off, zero divider
      do_tune(22'h00_1234, 8'h00);
      do_tune(22'h3F_FFFF, 8'h80);
      // priority: down beats up
      issue(1, 1, 0, '0, '0, "R11");
      check("R11 down wins", pwr_on, 0);
      wait_idle();
      // priority: up beats retune
      issue(1, 0, 1, 22'h2AAAA, 8'h02, "R11");
      check("R11 up wins", pwr_on, 1);
      wait_idle();
      check("R11 tune dropped", pdiv_out, exp_pdiv);
      exp_en = 1;
      do_tune(22'h0ABCD, 8'h08);
      do_down();
      do_up();
      do_tune(22'h3FFFF, 8'h06);

      // random mix
      for (int i = 0; i < 14; i++) begin
         int op = int'($urandom_range(0, 2));
         if (!exp_en) do_up();
         else if (op == 0) do_down();
         else do_tune(PCW_W'($urandom), DIV_W'($urandom));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule